// File: doc/BRIEF.md
# Keyed Watchdog and Interval Timer

This block counts ticks from one of two clock-enable strobes and acts either as a watchdog or as a periodic interval timer. As a watchdog, its expiry issues a one-cycle system reset request. As an interval timer, its expiry sets a sticky flag, and that flag can drive an interrupt. Software sets the block up through one 16-bit control word. A write takes effect only when its upper byte carries the access key 0x5A. Any other key is treated as a fault and requests a reset.

The control byte does several things:
- It picks the mode and the tick source.
- It picks one of four expiry periods.
- It can freeze the counter.
- It holds a self-clearing counter-clear command.
- It decides how the external reset pin is used. The pin can be a level-sensitive reset input, or an edge-detected non-maskable event input with a selectable polarity.

The pin passes through a two-flop synchronizer before it is used. Everything runs in one system clock domain.

Top module: `wdtKeyedTimer`

## Requirements
- R1: After reset, with the pin held high, the read word is 0x6900 and the reset request, flag, interrupt and NMI outputs are all 0.
- R2: A write whose upper byte is 0x5A loads bits 7:0 into the control byte. Bit fields: 7 hold, 6 NMI edge (0 rising, 1 falling), 5 pin function (0 reset, 1 NMI), 4 mode (0 watchdog, 1 interval), 3 counter clear, 2 tick source (0 first enable, 1 second enable), 1:0 interval select. The read word is 0x69 in the upper byte and the control byte in the lower byte, with bit 3 always read as 0.
- R3: A write with any other upper byte leaves the control byte unchanged and raises the reset request for exactly one cycle, starting in the cycle after the write.
- R4: While the hold bit is 1, the counter neither advances nor expires.
- R5: Only the tick source selected by bit 2 advances the counter; strobes on the other enable are ignored.
- R6: Measured from a counter clear, expiry occurs on tick number 32768, 8192, 512 or 64 for interval select 00, 01, 10 or 11.
- R7: In interval mode, expiry sets the flag, and the counter keeps running, so that the next expiry follows after a further full interval. The flag stays set until the flag-clear input is driven; a set wins over a clear in the same cycle. The interrupt output equals the flag ANDed with the interrupt-enable input.
- R8: In watchdog mode, expiry raises the reset request for one cycle, restores the control byte to 0x00 and restarts the counter from zero.
- R9: A keyed write with bit 3 set forces the counter to zero, taking priority over a tick in the same cycle.
- R10: With pin function 0, a synchronized low level on the pin drives the reset request from the second clock edge after the pin falls. With pin function 1, the pin never drives the reset request.
- R11: With pin function 1, the selected pin edge produces a one-cycle NMI event after the second clock edge that follows the pin change. Changing only the edge-select bit while the pin is steady produces no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEnA | input | 1 | First tick-source enable strobe |
| tickEnB | input | 1 | Second tick-source enable strobe |
| wrEn | input | 1 | Control-word write strobe |
| wrData | input | 16 | Write word: key in 15:8, control byte in 7:0 |
| rdData | output | 16 | Read word: 0x69 and the control byte |
| flagClr | input | 1 | Clears the interval flag |
| irqEn | input | 1 | Interrupt enable for the interval flag |
| pinIn | input | 1 | Asynchronous reset/NMI pin level |
| rstReq | output | 1 | System reset request |
| intvFlag | output | 1 | Sticky interval-expiry flag |
| irqOut | output | 1 | Interval interrupt |
| nmiEvent | output | 1 | One-cycle NMI event from the pin |

## Verification
The embedded properties check the following on every cycle:
- the reset pulse after a bad key, and that such a write leaves the control byte untouched;
- that a frozen counter stays frozen, and that the clear command zeroes the counter;
- that the flag stays set, and that a watchdog expiry restores the default control byte;
- that bit 3 never reads back as 1;
- that the NMI event lasts one cycle.

Only the bench scenarios can show the exact tick counts to expiry for each interval select, and that the unselected enable is ignored. They also show the two-edge latency of the pin paths and the absence of an event when only the edge-select bit changes. For these, a behavioural model is compared against the design's outputs on every clock.

// File: rtl/wdtPkg.sv
package wdtPkg;
  localparam logic [7:0] WR_KEY = 8'h5A;
  localparam logic [7:0] RD_KEY = 8'h69;

  localparam int HOLD_B  = 7;
  localparam int EDGE_B  = 6;
  localparam int PINFN_B = 5;
  localparam int MODE_B  = 4;
  localparam int CLR_B   = 3;
  localparam int SRC_B   = 2;

  typedef struct packed {
    logic       clr;
    logic       tick;
    logic [1:0] intvSel;
  } cntCmd_t;
endpackage

// File: rtl/wdtCounter.sv
module wdtCounter
  import wdtPkg::*;
#(
  parameter int CNT_W = 16,
  parameter int TAP0  = 15,
  parameter int TAP1  = 13,
  parameter int TAP2  = 9,
  parameter int TAP3  = 6
) (
  input  logic    clk,
  input  logic    rstN,
  input  cntCmd_t cmd,
  output logic    expire
);
  localparam int TAPW [4] = '{TAP0, TAP1, TAP2, TAP3};

  logic [CNT_W-1:0] cnt;
  logic [3:0]       lowAllOnes;

  // one carry detector per selectable period
  for (genvar i = 0; i < 4; i++) begin : gTap
    assign lowAllOnes[i] = &cnt[TAPW[i]-1:0];
  end

  assign expire = cmd.tick & lowAllOnes[cmd.intvSel];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         cnt <= '0;
    else if (cmd.clr)  cnt <= '0;
    else if (cmd.tick) cnt <= cnt + CNT_W'(1);
  end

  assert_hold_count_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.tick && !cmd.clr) |=> $stable(cnt));

  assert_clear_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    cmd.clr |=> (cnt == '0));
endmodule

// File: rtl/wdtControl.sv
module wdtControl
  import wdtPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickEnA,
  input  logic        tickEnB,
  input  logic        wrEn,
  input  logic [15:0] wrData,
  input  logic        flagClr,
  input  logic        irqEn,
  input  logic        expire,
  output cntCmd_t     cmd,
  output logic [7:0]  ctrlReg,
  output logic        rstPulse,
  output logic        intvFlag,
  output logic        irqOut
);
  logic keyOk;
  logic wdExpire;
  logic ivExpire;

  assign keyOk    = wrEn && (wrData[15:8] == WR_KEY);
  assign wdExpire = expire && !ctrlReg[MODE_B];
  assign ivExpire = expire && ctrlReg[MODE_B];

  always_comb begin
    cmd.clr     = (keyOk && wrData[CLR_B]) || wdExpire;
    cmd.tick    = !ctrlReg[HOLD_B] && (ctrlReg[SRC_B] ? tickEnB : tickEnA);
    cmd.intvSel = ctrlReg[1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg  <= '0;
      rstPulse <= 1'b0;
      intvFlag <= 1'b0;
    end else begin
      if (wdExpire)   ctrlReg <= '0;
      else if (keyOk) ctrlReg <= wrData[7:0] & ~(8'h01 << CLR_B);
      rstPulse <= (wrEn && !keyOk) || wdExpire;
      if (ivExpire)     intvFlag <= 1'b1;
      else if (flagClr) intvFlag <= 1'b0;
    end
  end

  assign irqOut = intvFlag & irqEn;

  assert_badkey_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[15:8] != WR_KEY) |=> rstPulse);

  assert_badkey_keep_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[15:8] != WR_KEY && !expire) |=> $stable(ctrlReg));

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (intvFlag && !flagClr) |=> intvFlag);

  assert_wd_default_R8: assert property (@(posedge clk) disable iff (!rstN)
    (expire && !ctrlReg[MODE_B]) |=> (ctrlReg == 8'h00 && rstPulse));

  assert_clr_reads0_R2: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlReg[CLR_B]);
endmodule

// File: rtl/wdtPinIn.sv
module wdtPinIn #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinIn,
  input  logic pinFn,
  input  logic edgeSel,
  output logic nmiEvent,
  output logic pinRst
);
  logic [SYNC_N:0] shReg;
  logic lvl;
  logic prevLvl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shReg <= '1;
    else       shReg <= {shReg[SYNC_N-1:0], pinIn};
  end

  assign lvl      = shReg[SYNC_N-1];
  assign prevLvl  = shReg[SYNC_N];
  assign nmiEvent = pinFn & (edgeSel ? (prevLvl & ~lvl) : (lvl & ~prevLvl));
  assign pinRst   = ~pinFn & ~lvl;

  assert_nmi_single_R11: assert property (@(posedge clk) disable iff (!rstN)
    nmiEvent |=> (!nmiEvent || !$stable(edgeSel)));
endmodule

// File: rtl/wdtKeyedTimer.sv
module wdtKeyedTimer
  import wdtPkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int TAP0   = 15,
  parameter int TAP1   = 13,
  parameter int TAP2   = 9,
  parameter int TAP3   = 6,
  parameter int SYNC_N = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickEnA,
  input  logic        tickEnB,
  input  logic        wrEn,
  input  logic [15:0] wrData,
  output logic [15:0] rdData,
  input  logic        flagClr,
  input  logic        irqEn,
  input  logic        pinIn,
  output logic        rstReq,
  output logic        intvFlag,
  output logic        irqOut,
  output logic        nmiEvent
);
  cntCmd_t    cmd;
  logic       expire;
  logic [7:0] ctrlReg;
  logic       rstPulse;
  logic       pinRst;

  wdtControl u_ctrl (
    .clk(clk), .rstN(rstN), .tickEnA(tickEnA), .tickEnB(tickEnB),
    .wrEn(wrEn), .wrData(wrData), .flagClr(flagClr), .irqEn(irqEn),
    .expire(expire), .cmd(cmd), .ctrlReg(ctrlReg), .rstPulse(rstPulse),
    .intvFlag(intvFlag), .irqOut(irqOut)
  );

  wdtCounter #(
    .CNT_W(CNT_W), .TAP0(TAP0), .TAP1(TAP1), .TAP2(TAP2), .TAP3(TAP3)
  ) u_cnt (
    .clk(clk), .rstN(rstN), .cmd(cmd), .expire(expire)
  );

  wdtPinIn #(.SYNC_N(SYNC_N)) u_pin (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .pinFn(ctrlReg[PINFN_B]),
    .edgeSel(ctrlReg[EDGE_B]), .nmiEvent(nmiEvent), .pinRst(pinRst)
  );

  assign rdData = {RD_KEY, ctrlReg};
  assign rstReq = rstPulse | pinRst;
endmodule

// File: tb/wdtKeyedTimer_tb.sv
module wdtKeyedTimer_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEnA = 1'b0, tickEnB = 1'b0, wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic flagClr = 1'b0, irqEn = 1'b0, pinIn = 1'b1;
  logic [15:0] rdData;
  logic rstReq, intvFlag, irqOut, nmiEvent;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wdtKeyedTimer u_dut (
    .clk(clk), .rstN(rstN), .tickEnA(tickEnA), .tickEnB(tickEnB),
    .wrEn(wrEn), .wrData(wrData), .rdData(rdData), .flagClr(flagClr),
    .irqEn(irqEn), .pinIn(pinIn), .rstReq(rstReq), .intvFlag(intvFlag),
    .irqOut(irqOut), .nmiEvent(nmiEvent)
  );

  // behavioural reference model
  int       mCnt;
  bit [7:0] mCtrl;
  bit       mFlag, mPulse;
  int       pinQ[$];
  bit       lastLvl;

  function automatic int intvOf(bit [1:0] s);
    case (s)
      2'b00:   return 32768;
      2'b01:   return 8192;
      2'b10:   return 512;
      default: return 64;
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCnt = 0; mCtrl = 0; mFlag = 0; mPulse = 0;
      pinQ = '{1, 1}; lastLvl = 1;
    end else begin
      bit tk, good, expd, wd;
      int per;
      tk   = !mCtrl[7] && (mCtrl[2] ? tickEnB : tickEnA);
      per  = intvOf(mCtrl[1:0]);
      good = wrEn && (wrData[15:8] == 8'h5A);
      expd = tk && (((mCnt + 1) % per) == 0);
      wd   = expd && !mCtrl[4];
      mPulse = (wrEn && !good) || wd;
      if (expd && mCtrl[4]) mFlag = 1;
      else if (flagClr)     mFlag = 0;
      if ((good && wrData[3]) || wd) mCnt = 0;
      else if (tk)                   mCnt = (mCnt + 1) % 65536;
      if (wd)        mCtrl = 0;
      else if (good) mCtrl = wrData[7:0] & 8'hF7;
      lastLvl = pinQ[0][0];
      void'(pinQ.pop_front());
      pinQ.push_back(int'(pinIn));
    end
  end

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare with the model every cycle, away from the edges
  always @(negedge clk) begin
    if (rstN && !done) begin
      bit lvl, eNmi, eRst;
      #2;
      lvl  = pinQ[0][0];
      eRst = mPulse || (!mCtrl[5] && !lvl);
      eNmi = mCtrl[5] && (mCtrl[6] ? (lastLvl && !lvl) : (lvl && !lastLvl));
      chk("R2 rdData", rdData, {8'h69, mCtrl});
      chk("R8 rstReq", 16'(rstReq), 16'(eRst));
      chk("R7 intvFlag", 16'(intvFlag), 16'(mFlag));
      chk("R7 irqOut", 16'(irqOut), 16'(mFlag && irqEn));
      chk("R11 nmiEvent", 16'(nmiEvent), 16'(eNmi));
    end
  end

  task automatic wr(logic [15:0] d);
    @(negedge clk); wrEn = 1; wrData = d;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic countFlag(output int n);
    n = 0;
    while (!intvFlag && n < 70000) begin
      @(negedge clk); #2; n++;
    end
  endtask

  task automatic pulseClr();
    @(negedge clk); flagClr = 1;
    @(negedge clk); flagClr = 0;
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rstN = 1;
    #2;
    chk("R1 reset rdData", rdData, 16'h6900);
    chk("R1 reset outputs", 16'({rstReq, intvFlag, irqOut, nmiEvent}), 16'h0);

    wr(16'h5A80); #2;
    chk("R2 hold write", rdData, 16'h6980);
    wr(16'h5A9B); #2;
    chk("R2 clr bit reads 0", rdData, 16'h6993);

    tickEnA = 1;
    repeat (200) @(negedge clk);
    #2; chk("R4 held no expiry", 16'(intvFlag), 16'h0);

    @(negedge clk); wrEn = 1; wrData = 16'h1234;
    @(negedge clk); wrEn = 0; #2;
    chk("R3 bad key pulse", 16'(rstReq), 16'h1);
    chk("R3 bad key keeps ctrl", rdData, 16'h6993);
    @(negedge clk); #2;
    chk("R3 pulse one cycle", 16'(rstReq), 16'h0);

    // each interval from a clear, in interval mode
    for (int s = 3; s >= 0; s--) begin
      pulseClr();
      wr(16'h5A18 | 16'(s));
      countFlag(n);
      chk("R6 ticks to expiry", 16'(n), 16'(intvOf(2'(s))));
    end

    // flag stays, interrupt gating, counter keeps running
    wr(16'h5A13);
    pulseClr();
    countFlag(n);
    repeat (10) @(negedge clk);
    #2; chk("R7 flag sticky", 16'(intvFlag), 16'h1);
    irqEn = 1; #1;
    chk("R7 irq enabled", 16'(irqOut), 16'h1);
    irqEn = 0; #1;
    chk("R7 irq masked", 16'(irqOut), 16'h0);
    @(negedge clk); flagClr = 1;
    @(negedge clk); flagClr = 0; #2;
    chk("R7 flag cleared", 16'(intvFlag), 16'h0);
    countFlag(n);
    chk("R7 continues running", 16'(n), 16'd52);

    // counter clear mid-interval
    pulseClr();
    wr(16'h5A1B);
    repeat (40) @(negedge clk);
    wr(16'h5A1B);
    countFlag(n);
    chk("R9 restart after clear", 16'(n), 16'd64);

    // tick source select
    pulseClr();
    wr(16'h5A1F);
    repeat (200) @(negedge clk);
    #2; chk("R5 other enable ignored", 16'(intvFlag), 16'h0);
    tickEnA = 0;
    wr(16'h5A1F);
    n = 0;
    while (!intvFlag && n < 1000) begin
      @(negedge clk); tickEnB = 1;
      @(negedge clk); tickEnB = 0; #2; n++;
    end
    chk("R5 second enable ticks", 16'(n), 16'd64);

    // watchdog expiry
    pulseClr();
    tickEnA = 1;
    wr(16'h5A0B);
    n = 0;
    while (!rstReq && n < 1000) begin
      @(negedge clk); #2; n++;
    end
    chk("R8 watchdog ticks", 16'(n), 16'd64);
    chk("R8 defaults restored", rdData, 16'h6900);
    tickEnA = 0;
    @(negedge clk); #2;
    chk("R8 reset one cycle", 16'(rstReq), 16'h0);

    // pin as reset input
    @(negedge clk); pinIn = 0;
    @(negedge clk); #2;
    chk("R10 one edge not yet", 16'(rstReq), 16'h0);
    @(negedge clk); #2;
    chk("R10 pin reset", 16'(rstReq), 16'h1);
    pinIn = 1;
    repeat (3) @(negedge clk);
    wr(16'h5A20);
    @(negedge clk); pinIn = 0;
    repeat (3) @(negedge clk); #2;
    chk("R10 NMI mode no reset", 16'(rstReq), 16'h0);
    chk("R11 falling ignored when rising", 16'(nmiEvent), 16'h0);

    // NMI edges
    @(negedge clk); pinIn = 1;
    @(negedge clk);
    @(negedge clk); #2;
    chk("R11 rising event", 16'(nmiEvent), 16'h1);
    @(negedge clk); #2;
    chk("R11 event one cycle", 16'(nmiEvent), 16'h0);
    wr(16'h5A60);
    repeat (3) @(negedge clk); #2;
    chk("R11 edge select change no event", 16'(nmiEvent), 16'h0);
    @(negedge clk); pinIn = 0;
    @(negedge clk);
    @(negedge clk); #2;
    chk("R11 falling event", 16'(nmiEvent), 16'h1);
    repeat (4) @(negedge clk);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule